// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command decoder for a serial NOR flash. It sits between the SPI pins and the flash core. It oversamples the serial clock and chip-select with the core clock and assembles 8-bit cycles. It decodes the first byte of each frame as an opcode, collects a 24-bit address where the command has one, and drives the serial output for reads, status and identification. Read data comes from an external array port: the block presents the current byte address, and the port returns that byte in the same cycle.

Program, erase and status-write commands go through a write-enable latch. They take effect only when chip-select rises exactly on a byte boundary after the correct number of bytes. They appear as a single-cycle request carrying a kind code, an address and a data byte. Page-program data bytes are also passed out one at a time as staging writes. Their address wraps inside the 256-byte page. The SPI pins are assumed to be synchronous to `clk`, with each SCK phase lasting at least two `clk` cycles.

Top module: `sflash_cmd_fe`

## Requirements
- R1: SPI mode 0 is used. MOSI is sampled on each SCK rise, most significant bit first, in 8-bit cycles. MISO changes on SCK falls, and the first bit of a byte is presented after the last fall of the preceding byte.
- R2: If chip-select rises while a byte is incomplete, the frame is dropped. No request is issued and the write-enable latch keeps its value.
- R3: Opcode 06h sets the write-enable latch and 04h clears it, each as a one-byte frame. Opcode 05h returns `{status_in[7:2], latch, status_in[0]}` in every following byte.
- R4: Without the latch set, opcodes 02h, ADh, 20h, D8h, 60h and C7h produce neither `op_req` nor `stage_we`.
- R5: After any accepted modify request, the write-enable latch reads back as 0.
- R6: Opcode 03h takes three address bytes, high byte first. It then streams `rd_data` for consecutive addresses while chip-select stays low. The address rolls over at 24 bits.
- R7: Opcode 0Bh inserts one dummy byte after the address before the data stream starts.
- R8: A 4-byte frame of 20h requests kind 3 with address bits [11:0] cleared. A 4-byte frame of D8h requests kind 4 with bits [15:0] cleared. A one-byte frame of 60h or C7h requests kind 5 with address 0.
- R9: Opcodes 02h and ADh need at least one data byte after the address. Each data byte pulses `stage_we`, and the low address byte wraps within the page. The final request uses kind 1 (02h) or kind 2 (ADh) and carries the page base address.
- R10: Opcode 01h followed by exactly one data byte requests kind 6 with that byte on `op_data`. It is accepted if the latch is set, or if the frame just before it was a one-byte 50h.
- R11: Opcode 9Fh returns 8Ch, 20h and 14h, then 00h, and the four-byte pattern repeats.
- R12: Opcode 90h takes three bytes, the last of which selects the order. If its bit 0 is 0, the bytes alternate 8Ch, 13h. If it is 1, they alternate 13h, 8Ch.
- R13: `spi_miso_oe` is low while chip-select is high and during opcode, address and dummy bytes. It rises only after an SCK fall.
- R14: `op_req` is high for exactly one `clk` cycle: the cycle after chip-select is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| status_in | input | 8 | Status byte from the core (bit 1 is replaced) |
| rd_addr | output | 24 | Current read address |
| rd_data | input | 8 | Array byte at rd_addr |
| stage_we | output | 1 | One-cycle strobe per program data byte |
| stage_addr | output | 24 | Address of the staged byte |
| stage_data | output | 8 | Staged data byte |
| op_req | output | 1 | One-cycle modify request |
| op_kind | output | 3 | 1 page, 2 word-stream, 3 sector, 4 block, 5 chip, 6 status |
| op_addr | output | 24 | Request address |
| op_data | output | 8 | Status byte or last program byte |

## Verification
A stray write-enable latch is the most damaging internal fault. It shows on the next status read as bit 1, and on the next modify frame as a request that should not exist. Both appear within one frame. A byte or bit counter that is off by one makes the read stream start one byte early or late. That error is visible in the first output byte after the address, or as a missing request at the chip-select rise that ends the frame. A wrong address register appears in the first streamed byte and in the masked erase address.

// File: rtl/sflash_cmd_fe.sv
module sflash_cmd_fe #(
  parameter logic [7:0] MFR_ID  = 8'h8C,
  parameter logic [7:0] TYPE_ID = 8'h20,
  parameter logic [7:0] CAP_ID  = 8'h14,
  parameter logic [7:0] DEV_ID  = 8'h13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  input  logic [7:0]  status_in,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        stage_we,
  output logic [23:0] stage_addr,
  output logic [7:0]  stage_data,
  output logic        op_req,
  output logic [2:0]  op_kind,
  output logic [23:0] op_addr,
  output logic [7:0]  op_data
);
  localparam logic [2:0] K_PAGE = 3'd1, K_WORD = 3'd2, K_SECT = 3'd3,
                         K_BLK = 3'd4, K_CHIP = 3'd5, K_STAT = 3'd6;

  logic        sck_q, cs_q, wel, ewsr, out_act;
  logic [2:0]  bit_cnt;
  logic [3:0]  byte_cnt;
  logic [7:0]  rx, opc, data_q, tx;
  logic [23:0] addr;

  wire       sck_rise  = spi_sck & ~sck_q;
  wire       sck_fall  = ~spi_sck & sck_q;
  wire       cs_rise   = spi_cs_n & ~cs_q;
  wire [7:0] rx_next   = {rx[6:0], spi_mosi};
  wire       byte_done = sck_rise && bit_cnt == 3'd7;
  wire       on_bound  = bit_cnt == 3'd0;
  wire       is_prog   = opc == 8'h02 || opc == 8'hAD;
  wire       has_addr  = is_prog || opc == 8'h03 || opc == 8'h0B ||
                         opc == 8'h20 || opc == 8'hD8 || opc == 8'h90;
  wire [7:0] status_out = {status_in[7:2], wel, status_in[0]};

  assign spi_miso    = tx[7];
  assign spi_miso_oe = ~spi_cs_n & out_act;
  assign rd_addr     = addr;

  logic       go, wel_set, wel_clr, ewsr_set;
  logic [2:0] go_kind;
  logic [23:0] go_addr;

  always_comb begin
    go = 1'b0; go_kind = 3'd0; go_addr = 24'd0;
    wel_set = 1'b0; wel_clr = 1'b0; ewsr_set = 1'b0;
    if (on_bound) begin
      case (opc)
        8'h06: wel_set  = byte_cnt == 4'd1;
        8'h04: wel_clr  = byte_cnt == 4'd1;
        8'h50: ewsr_set = byte_cnt == 4'd1;
        8'h01: begin go = byte_cnt == 4'd2 && (wel || ewsr); go_kind = K_STAT; end
        8'h20: begin go = byte_cnt == 4'd4 && wel; go_kind = K_SECT; go_addr = {addr[23:12], 12'h000}; end
        8'hD8: begin go = byte_cnt == 4'd4 && wel; go_kind = K_BLK;  go_addr = {addr[23:16], 16'h0000}; end
        8'h60, 8'hC7: begin go = byte_cnt == 4'd1 && wel; go_kind = K_CHIP; end
        8'h02, 8'hAD: begin
          go = byte_cnt >= 4'd5 && wel;
          go_kind = (opc == 8'h02) ? K_PAGE : K_WORD;
          go_addr = {addr[23:8], 8'h00};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= spi_sck;
      cs_q  <= spi_cs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0; byte_cnt <= '0; rx <= '0; opc <= '0; data_q <= '0; tx <= '0;
      addr <= '0; wel <= 1'b0; ewsr <= 1'b0; out_act <= 1'b0;
      stage_we <= 1'b0; stage_addr <= '0; stage_data <= '0;
      op_req <= 1'b0; op_kind <= '0; op_addr <= '0; op_data <= '0;
    end else begin
      stage_we <= 1'b0;
      op_req   <= 1'b0;
      if (spi_cs_n) begin
        bit_cnt <= '0; byte_cnt <= '0; opc <= '0; addr <= '0; tx <= '0; out_act <= 1'b0;
        if (cs_rise) begin
          ewsr <= ewsr_set;
          if (wel_set) wel <= 1'b1;
          if (wel_clr) wel <= 1'b0;
          if (go) begin
            wel <= 1'b0; op_req <= 1'b1; op_kind <= go_kind;
            op_addr <= go_addr; op_data <= data_q;
          end
        end
      end else begin
        if (sck_rise) begin
          rx <= rx_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (has_addr && byte_cnt >= 4'd1 && byte_cnt <= 4'd3) addr <= {addr[22:0], spi_mosi};
        end
        if (byte_done) begin
          if (byte_cnt != 4'hF) byte_cnt <= byte_cnt + 4'd1;
          if (byte_cnt == 4'd0) opc <= rx_next;
          if (byte_cnt == 4'd1 && opc == 8'h01) data_q <= rx_next;
          if (byte_cnt >= 4'd4 && is_prog && wel) begin
            stage_we <= 1'b1; stage_addr <= addr; stage_data <= rx_next;
            data_q <= rx_next; addr[7:0] <= addr[7:0] + 8'd1;
          end
        end
        if (sck_fall) begin
          if (on_bound && byte_cnt != 4'd0) begin
            tx <= 8'h00;
            case (opc)
              8'h03: if (byte_cnt >= 4'd4) begin tx <= rd_data; addr <= addr + 24'd1; out_act <= 1'b1; end
              8'h0B: if (byte_cnt >= 4'd5) begin tx <= rd_data; addr <= addr + 24'd1; out_act <= 1'b1; end
              8'h05: begin tx <= status_out; out_act <= 1'b1; end
              8'h9F: begin
                case (addr[1:0])
                  2'd0: tx <= MFR_ID;
                  2'd1: tx <= TYPE_ID;
                  2'd2: tx <= CAP_ID;
                  default: tx <= 8'h00;
                endcase
                addr <= addr + 24'd1; out_act <= 1'b1;
              end
              8'h90: if (byte_cnt >= 4'd4) begin
                tx <= addr[0] ? DEV_ID : MFR_ID; addr <= addr + 24'd1; out_act <= 1'b1;
              end
              default: ;
            endcase
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_fe_chk.sv
module sflash_cmd_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic       op_req,
  input logic [2:0] op_kind,
  input logic       stage_we,
  input logic       wel
);
  assert_modify_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_kind != 3'd6) |-> $past(wel));
  assert_latch_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> !wel);
  assert_single_strobe_R14: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> !op_req);
  assert_strobe_after_cs_R14: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> $past(spi_cs_n));
  assert_stage_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |-> !$past(spi_cs_n));
  assert_oe_after_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> !$past(spi_sck));
endmodule

bind sflash_cmd_fe sflash_cmd_fe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_miso_oe(spi_miso_oe), .op_req(op_req), .op_kind(op_kind),
  .stage_we(stage_we), .wel(wel)
);

// File: tb/sflash_cmd_fe_tb_top.sv
module sflash_cmd_fe_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, stage_we, op_req;
  logic [7:0] status_in = 8'h81, rd_data, stage_data, op_data;
  logic [23:0] rd_addr, stage_addr, op_addr;
  logic [2:0] op_kind;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  assign rd_data = mem(rd_addr);

  sflash_cmd_fe dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .status_in(status_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .stage_we(stage_we), .stage_addr(stage_addr),
    .stage_data(stage_data), .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data)
  );

  int checks = 0, errors = 0;
  int op_cnt = 0, st_cnt = 0;
  logic [2:0] op_k; logic [23:0] op_a; logic [7:0] op_d;
  logic [23:0] st_a [8]; logic [7:0] st_d [8];

  always @(negedge clk) begin
    if (op_req) begin op_cnt++; op_k = op_kind; op_a = op_addr; op_d = op_data; end
    if (stage_we) begin st_a[st_cnt%8] = stage_addr; st_d[st_cnt%8] = stage_data; st_cnt++; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] din, input int nb, output logic [7:0] dout, output logic oe);
    dout = 8'h00; oe = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk) spi_mosi = din[i];
      repeat (3) @(negedge clk);
      dout[i] = spi_miso;
      if (i == 7) oe = spi_miso_oe;
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic bx(input logic [7:0] din);
    logic [7:0] d; logic o;
    xfer(din, 8, d, o);
  endtask

  task automatic cs_lo;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi;
    @(negedge clk) spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic one_byte(input logic [7:0] opc);
    cs_lo; bx(opc); cs_hi;
  endtask

  task automatic addr_cmd(input logic [7:0] opc, input logic [23:0] a);
    bx(opc); bx(a[23:16]); bx(a[15:8]); bx(a[7:0]);
  endtask

  task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
    logic o;
    cs_lo; bx(8'h05); xfer(8'h00, 8, s0, o); xfer(8'h00, 8, s1, o); cs_hi;
  endtask

  task automatic test_reset;
    chk("R14 no request after reset", op_cnt, 0);
    chk("R13 oe low after reset", spi_miso_oe, 0);
  endtask

  task automatic test_status;
    logic [7:0] a, b;
    read_status(a, b);
    chk("R3 status latch clear", a, 8'h81);
    one_byte(8'h06);
    read_status(a, b);
    chk("R3 status after 06h", a, 8'h83);
    chk("R3 status repeats", b, 8'h83);
    one_byte(8'h04);
    read_status(a, b);
    chk("R3 status after 04h", a, 8'h81);
  endtask

  task automatic test_abort;
    logic [7:0] a, b, d; logic o;
    cs_lo; xfer(8'h06, 5, d, o); cs_hi;
    read_status(a, b);
    chk("R2 partial 06h ignored", a, 8'h81);
    one_byte(8'h06);
    cs_lo; bx(8'h60); xfer(8'h00, 3, d, o); cs_hi;
    chk("R2 aborted chip erase no request", op_cnt, 0);
    read_status(a, b);
    chk("R2 latch kept after abort", a, 8'h83);
    one_byte(8'h04);
  endtask

  task automatic test_gate;
    int o0 = op_cnt, s0 = st_cnt;
    cs_lo; addr_cmd(8'h20, 24'h123456); cs_hi;
    chk("R4 sector erase without latch", op_cnt, o0);
    cs_lo; addr_cmd(8'h02, 24'h000010); bx(8'h77); cs_hi;
    chk("R4 program without latch no request", op_cnt, o0);
    chk("R4 program without latch no stage", st_cnt, s0);
    cs_lo; bx(8'hC7); cs_hi;
    chk("R4 chip erase without latch", op_cnt, o0);
  endtask

  task automatic test_erase;
    logic [7:0] a, b;
    int o0;
    one_byte(8'h06); o0 = op_cnt;
    cs_lo; addr_cmd(8'h20, 24'h123456); cs_hi;
    chk("R8 sector count", op_cnt, o0 + 1);
    chk("R8 sector kind", op_k, 3);
    chk("R8 sector addr", op_a, 24'h123000);
    read_status(a, b);
    chk("R5 latch cleared after erase", a, 8'h81);
    one_byte(8'h06);
    cs_lo; addr_cmd(8'hD8, 24'h123456); cs_hi;
    chk("R8 block kind", op_k, 4);
    chk("R8 block addr", op_a, 24'h120000);
    one_byte(8'h06);
    cs_lo; bx(8'hC7); cs_hi;
    chk("R8 chip C7h kind", op_k, 5);
    one_byte(8'h06); o0 = op_cnt;
    cs_lo; bx(8'h60); cs_hi;
    chk("R8 chip 60h count", op_cnt, o0 + 1);
    chk("R8 chip 60h addr", op_a, 0);
  endtask

  task automatic test_program;
    logic [7:0] a, b;
    int s0, o0;
    one_byte(8'h06); s0 = st_cnt; o0 = op_cnt;
    cs_lo; addr_cmd(8'h02, 24'h0456FE); bx(8'h11); bx(8'h22); bx(8'h33); cs_hi;
    chk("R9 stage count", st_cnt, s0 + 3);
    chk("R9 stage addr 0", st_a[s0 % 8], 24'h0456FE);
    chk("R9 stage addr 1", st_a[(s0 + 1) % 8], 24'h0456FF);
    chk("R9 stage addr wraps", st_a[(s0 + 2) % 8], 24'h045600);
    chk("R9 stage data", st_d[(s0 + 2) % 8], 8'h33);
    chk("R9 page request", op_cnt, o0 + 1);
    chk("R9 page kind", op_k, 1);
    chk("R9 page base", op_a, 24'h045600);
    one_byte(8'h06);
    cs_lo; addr_cmd(8'hAD, 24'h000100); bx(8'hAA); bx(8'hBB); cs_hi;
    chk("R9 word-stream kind", op_k, 2);
    one_byte(8'h06); o0 = op_cnt;
    cs_lo; addr_cmd(8'h02, 24'h000200); cs_hi;
    chk("R9 no data byte no request", op_cnt, o0);
    read_status(a, b);
    chk("R9 latch kept without data", a, 8'h83);
    one_byte(8'h04);
  endtask

  task automatic test_wrsr;
    int o0 = op_cnt;
    cs_lo; bx(8'h01); bx(8'h3C); cs_hi;
    chk("R10 status write without enable", op_cnt, o0);
    one_byte(8'h50);
    cs_lo; bx(8'h01); bx(8'h3C); cs_hi;
    chk("R10 after 50h count", op_cnt, o0 + 1);
    chk("R10 kind", op_k, 6);
    chk("R10 data", op_d, 8'h3C);
    one_byte(8'h06);
    cs_lo; bx(8'h01); bx(8'h5A); cs_hi;
    chk("R10 after 06h data", op_d, 8'h5A);
  endtask

  task automatic test_read;
    logic [7:0] d; logic o;
    cs_lo;
    xfer(8'h03, 8, d, o);
    xfer(8'h12, 8, d, o); chk("R13 oe low in address", o, 0);
    xfer(8'h34, 8, d, o);
    xfer(8'hFE, 8, d, o); chk("R13 oe low in last address", o, 0);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, 8, d, o);
      chk("R1 R6 read stream byte", d, mem(24'h1234FE + 24'(i)));
      chk("R13 oe high in data", o, 1);
    end
    cs_hi;
    chk("R13 oe low after frame", spi_miso_oe, 0);
  endtask

  task automatic test_fast;
    logic [7:0] d; logic o;
    cs_lo; addr_cmd(8'h0B, 24'h001020);
    xfer(8'h00, 8, d, o); chk("R7 dummy oe low", o, 0);
    xfer(8'h00, 8, d, o); chk("R7 first data", d, mem(24'h001020));
    xfer(8'h00, 8, d, o); chk("R7 second data", d, mem(24'h001021));
    cs_hi;
  endtask

  task automatic test_ids;
    logic [7:0] d; logic o;
    cs_lo; bx(8'h9F);
    xfer(8'h00, 8, d, o); chk("R11 byte0", d, 8'h8C);
    xfer(8'h00, 8, d, o); chk("R11 byte1", d, 8'h20);
    xfer(8'h00, 8, d, o); chk("R11 byte2", d, 8'h14);
    cs_hi;
    cs_lo; addr_cmd(8'h90, 24'h000000);
    xfer(8'h00, 8, d, o); chk("R12 sel0 first", d, 8'h8C);
    xfer(8'h00, 8, d, o); chk("R12 sel0 second", d, 8'h13);
    xfer(8'h00, 8, d, o); chk("R12 sel0 third", d, 8'h8C);
    cs_hi;
    cs_lo; addr_cmd(8'h90, 24'h000001);
    xfer(8'h00, 8, d, o); chk("R12 sel1 first", d, 8'h13);
    xfer(8'h00, 8, d, o); chk("R12 sel1 second", d, 8'h8C);
    cs_hi;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset;
    test_status;
    test_abort;
    test_gate;
    test_erase;
    test_program;
    test_wrsr;
    test_read;
    test_fast;
    test_ids;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule